// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block is the host-side engine for an asynchronous x16 NAND flash bus whose I/O lines carry commands, addresses and data in turn. A requester hands it one operation at a time on a valid/ready handshake: an operation code, a row (page) address, a column address and a word count. The sequencer then runs the whole bus sequence for that operation. It raises the command and address latch strobes, pulses the write and read strobes with cycle counts set by parameters, drives or samples the 16-bit bus, and waits on the open-drain ready/busy line whenever the flash runs an internal operation.

Program and erase operations end with a status poll. The pass/fail bit of the returned status goes back to the requester together with the done pulse. Read data, status words and identifier words are handed out one word at a time on a read-valid strobe. Write data is pulled from the requester with a take strobe, one pulse per word. The sequencer keeps track of whether a cache read is open, so that a random data output that would be illegal during a cache read is refused.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, reqReady=1, ceN=1, weN=1, reN=1, cle=0, ale=0, done=0 and wpN=0.
- R2: Operation code 0 (page read) issues command 00h, then the column bytes low byte first, then the row bytes low byte first, then command 30h. It waits for rbN to go low and then high, and then performs reqLen read cycles. Each read word is delivered in order on rdData with rdValid, and the operation ends with done and fail=0.
- R3: Operation code 2 (program) issues 80h, the column and row bytes, reqLen data-in cycles carrying successive wrData words (one wrTake per word), and then 10h. It waits for busy to end, issues 70h and performs one read. fail is taken from bit 0 of that status word (1 means failed).
- R4: Operation code 3 (cache program) runs the same sequence as code 2 but confirms with 15h instead of 10h.
- R5: Operation code 4 (block erase) issues 60h, the row bytes only, then D0h. It waits for busy to end, then polls status with 70h, and fail equals status bit 0.
- R6: Operation code 5 (random data output) issues 05h, the column bytes and E0h, then performs reqLen read cycles without waiting on rbN.
- R7: Operation code 6 (random data input) issues 85h, the column bytes and reqLen data-in cycles, and then ends with no confirm command and no busy wait.
- R8: Operation code 1 (cache read) runs like code 0 but confirms with 31h, and it marks a cache read as open. Codes 5 and 7 leave the mark unchanged and every other code clears it. A code 5 request made while the mark is set ends with done and fail=1, and it produces no WE or RE pulse.
- R9: Operation code 7 (read status) issues 70h, performs one read cycle and delivers the status word on rdData with rdValid.
- R10: Operation code 8 (read identifier) issues 90h and one address cycle of 00h, then performs four read cycles. All four words are delivered in order, and the first one is the manufacturer code ADh.
- R11: Operation code 9 (reset) issues FFh, waits for rbN to go low and then return high, and raises done only after that.
- R12: Every command, address and data-in cycle holds weN low for exactly WE_LO clocks and then high for WE_HI clocks. Every read cycle holds reN low for exactly RE_LO clocks, and the bus is sampled RE_SMP clocks after reN falls. weN and reN are never low at the same time.
- R13: wpN is high during codes 2, 3, 4 and 6 and low during every other operation and when idle. In particular it is high whenever 10h, 15h or D0h is written.
- R14: All address cycles of an operation come from the row and column captured when the request is accepted. A later change of reqRow or reqCol has no effect, so the top row bit is identical in every cycle of one operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Operation request valid |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqOp | input | 4 | Operation code (0..9) |
| reqRow | input | ROWW | Row (page) address |
| reqCol | input | COLW | Column address |
| reqLen | input | LENW | Number of data words |
| wrData | input | 16 | Write data word for the current data-in cycle |
| wrTake | output | 1 | Pulse: wrData is taken this cycle |
| rdData | output | 16 | Read, status or identifier word |
| rdValid | output | 1 | Pulse: rdData holds a new word |
| done | output | 1 | Pulse: operation finished |
| fail | output | 1 | With done: operation failed or was refused |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ceN | output | 1 | Chip enable, active low |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| wpN | output | 1 | Write protect, active low |
| ioOut | output | 16 | Bus value driven by the host |
| ioOe | output | 1 | Host drives the bus |
| ioIn | input | 16 | Bus value from the flash |
| rbN | input | 1 | Ready/busy from the flash, low while busy |

## Verification
The bench goes after the places where a sequencer goes wrong quietly. It sweeps the word count from one upward, which exposes any off-by-one that would drop or add a data cycle. It drives a row with the top bit set and then corrupts the request fields right after acceptance; a design that reads live inputs would emit mixed address bytes. It opens a cache read, runs a status poll and then asks for random output: a design that loses the cache mark, or lets the status poll clear it, would put strobes on the bus instead of refusing. It stretches busy during reset, and it returns a failing status after program and erase, so that an early done or an inverted pass/fail bit shows up.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;
  typedef enum logic [3:0] {
    OP_READ   = 4'd0,
    OP_CREAD  = 4'd1,
    OP_PROG   = 4'd2,
    OP_CPROG  = 4'd3,
    OP_ERASE  = 4'd4,
    OP_RNDOUT = 4'd5,
    OP_RNDIN  = 4'd6,
    OP_STATUS = 4'd7,
    OP_ID     = 4'd8,
    OP_RESET  = 4'd9
  } op_e;

  typedef enum logic [1:0] {CY_CMD, CY_ADDR, CY_WR, CY_RD} cyc_e;

  typedef struct packed {
    logic        start;
    cyc_e        kind;
    logic [15:0] value;
    logic        ceOn;
    logic        wpOn;
  } strobe_t;
endpackage

// File: rtl/nand_seq_dpath.sv
`timescale 1ns/1ps
module nand_seq_dpath
  import nand_seq_pkg::*;
#(
  parameter int WE_LO  = 2,
  parameter int WE_HI  = 2,
  parameter int RE_LO  = 3,
  parameter int RE_HI  = 2,
  parameter int RE_SMP = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [15:0] ioIn,
  output logic        cycDone,
  output logic        sampleValid,
  output logic [15:0] sampleData,
  output logic        cle,
  output logic        ale,
  output logic        ceN,
  output logic        weN,
  output logic        reN,
  output logic        wpN,
  output logic [15:0] ioOut,
  output logic        ioOe
);
  localparam int WTOT = WE_LO + WE_HI;
  localparam int RTOT = RE_LO + RE_HI;
  localparam int MAXT = (WTOT > RTOT) ? WTOT : RTOT;
  localparam int CW   = $clog2(MAXT + 1);

  logic          busy;
  cyc_e          kind;
  logic [15:0]   val;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lastCnt;
  logic          isRd;

  assign isRd    = (kind == CY_RD);
  assign lastCnt = isRd ? CW'(RTOT - 1) : CW'(WTOT - 1);
  assign cycDone = busy && (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      kind        <= CY_CMD;
      val         <= '0;
      cnt         <= '0;
      sampleValid <= 1'b0;
      sampleData  <= '0;
    end else begin
      sampleValid <= 1'b0;
      if (stb.start) begin
        busy <= 1'b1;
        cnt  <= '0;
        kind <= stb.kind;
        val  <= stb.value;
      end else if (busy) begin
        if (cnt == lastCnt) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (isRd && cnt == CW'(RE_SMP - 1)) begin
          sampleValid <= 1'b1;
          sampleData  <= ioIn;
        end
      end
    end
  end

  assign cle   = busy && (kind == CY_CMD);
  assign ale   = busy && (kind == CY_ADDR);
  assign ioOut = val;
  assign ioOe  = busy && !isRd;
  assign weN   = !(busy && !isRd && cnt < CW'(WE_LO));
  assign reN   = !(busy && isRd && cnt < CW'(RE_LO));
  assign ceN   = !stb.ceOn;
  assign wpN   = stb.wpOn;

  // R12: strobes never overlap, and the host never drives during a read
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));
  assert_no_drive_on_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !ioOe);
  assert_start_when_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |-> !busy);
endmodule

// File: rtl/nand_seq_ctrl.sv
`timescale 1ns/1ps
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int COLW  = 12,
  parameter int ROWW  = 16,
  parameter int LENW  = 8,
  parameter int SYNCN = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  op_e             reqOp,
  input  logic [ROWW-1:0] reqRow,
  input  logic [COLW-1:0] reqCol,
  input  logic [LENW-1:0] reqLen,
  input  logic [15:0]     wrData,
  output logic            wrTake,
  output logic [15:0]     rdData,
  output logic            rdValid,
  output logic            done,
  output logic            fail,
  input  logic            rbN,
  output strobe_t         stb,
  input  logic            cycDone,
  input  logic            sampleValid,
  input  logic [15:0]     sampleData
);
  localparam int COLCYC = (COLW + 7) / 8;
  localparam int ROWCYC = (ROWW + 7) / 8;
  localparam int ACYC   = COLCYC + ROWCYC;
  localparam int AIW    = $clog2(ACYC + 1);
  localparam int CPB    = 8 * COLCYC;
  localparam int RPB    = 8 * ROWCYC;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WLOW, S_WHIGH,
    S_STCMD, S_STRD, S_RDATA, S_FIN
  } st_e;

  st_e             state;
  op_e             opReg;
  logic [ROWW-1:0] rowReg;
  logic [COLW-1:0] colReg;
  logic [LENW-1:0] lenReg;
  logic [LENW-1:0] dCnt;
  logic [AIW-1:0]  aIdx, aEnd;
  logic            inFlight, cacheOn, failReg;
  logic [SYNCN-1:0] rbPipe;
  logic            rbOk, stepDone, progKind;
  logic [RPB+CPB-1:0] addrVec;
  logic [7:0]      addrByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rbPipe <= '1;
    else       rbPipe <= {rbPipe[SYNCN-2:0], rbN};
  end
  assign rbOk = rbPipe[SYNCN-1];

  assign addrVec  = {RPB'(rowReg), CPB'(colReg)};
  assign addrByte = addrVec[{aIdx, 3'b000} +: 8];
  assign stepDone = inFlight && cycDone;
  assign progKind = (opReg == OP_PROG) || (opReg == OP_CPROG) ||
                    (opReg == OP_ERASE) || (opReg == OP_RNDIN);

  function automatic logic [7:0] firstCode(op_e op);
    case (op)
      OP_PROG, OP_CPROG: return 8'h80;
      OP_ERASE:          return 8'h60;
      OP_RNDOUT:         return 8'h05;
      OP_RNDIN:          return 8'h85;
      OP_STATUS:         return 8'h70;
      OP_ID:             return 8'h90;
      OP_RESET:          return 8'hFF;
      default:           return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] confirmCode(op_e op);
    case (op)
      OP_CREAD:  return 8'h31;
      OP_PROG:   return 8'h10;
      OP_CPROG:  return 8'h15;
      OP_ERASE:  return 8'hD0;
      OP_RNDOUT: return 8'hE0;
      default:   return 8'h30;
    endcase
  endfunction

  always_comb begin
    stb.start = 1'b0;
    stb.kind  = CY_CMD;
    stb.value = '0;
    case (state)
      S_CMD1:  begin stb.start = !inFlight; stb.value = {8'h00, firstCode(opReg)}; end
      S_CMD2:  begin stb.start = !inFlight; stb.value = {8'h00, confirmCode(opReg)}; end
      S_STCMD: begin stb.start = !inFlight; stb.value = 16'h0070; end
      S_ADDR:  begin stb.start = !inFlight; stb.kind = CY_ADDR; stb.value = {8'h00, addrByte}; end
      S_WDATA: begin stb.start = !inFlight; stb.kind = CY_WR; stb.value = wrData; end
      S_STRD, S_RDATA: begin stb.start = !inFlight; stb.kind = CY_RD; end
      default: ;
    endcase
    stb.ceOn = (state != S_IDLE) && (state != S_FIN);
    stb.wpOn = stb.ceOn && progKind;
  end

  assign wrTake   = stb.start && (state == S_WDATA);
  assign reqReady = (state == S_IDLE);
  assign rdData   = sampleData;
  assign rdValid  = sampleValid &&
                    ((state == S_RDATA) || (state == S_STRD && opReg == OP_STATUS));
  assign done     = (state == S_FIN);
  assign fail     = done && failReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; opReg <= OP_READ; rowReg <= '0; colReg <= '0;
      lenReg <= '0; dCnt <= '0; aIdx <= '0; aEnd <= '0;
      inFlight <= 1'b0; cacheOn <= 1'b0; failReg <= 1'b0;
    end else begin
      if (stb.start) inFlight <= 1'b1;
      else if (cycDone) inFlight <= 1'b0;
      if (state == S_STRD && sampleValid && opReg != OP_STATUS) failReg <= sampleData[0];
      case (state)
        S_IDLE: if (reqValid) begin
          opReg   <= reqOp;
          rowReg  <= reqRow;
          colReg  <= (reqOp == OP_ID) ? '0 : reqCol;
          lenReg  <= (reqOp == OP_ID) ? LENW'(4) : reqLen;
          dCnt    <= '0;
          failReg <= 1'b0;
          aIdx    <= (reqOp == OP_ERASE) ? AIW'(COLCYC) : '0;
          aEnd    <= (reqOp == OP_RNDOUT || reqOp == OP_RNDIN) ? AIW'(COLCYC - 1) :
                     (reqOp == OP_ID) ? '0 : AIW'(ACYC - 1);
          if ((reqOp == OP_RNDOUT && cacheOn) || 4'(reqOp) > 4'd9) begin
            state   <= S_FIN;
            failReg <= 1'b1;
          end else begin
            state <= S_CMD1;
            if (reqOp == OP_CREAD) cacheOn <= 1'b1;
            else if (reqOp != OP_RNDOUT && reqOp != OP_STATUS) cacheOn <= 1'b0;
          end
        end
        S_CMD1: if (stepDone) begin
          if (opReg == OP_RESET)       state <= S_WLOW;
          else if (opReg == OP_STATUS) state <= S_STRD;
          else                         state <= S_ADDR;
        end
        S_ADDR: if (stepDone) begin
          if (aIdx != aEnd) aIdx <= aIdx + 1'b1;
          else if (opReg == OP_ID) state <= S_RDATA;
          else if (opReg == OP_PROG || opReg == OP_CPROG || opReg == OP_RNDIN) begin
            if (lenReg != '0)          state <= S_WDATA;
            else if (opReg == OP_RNDIN) state <= S_FIN;
            else                       state <= S_CMD2;
          end else state <= S_CMD2;
        end
        S_WDATA: if (stepDone) begin
          if (dCnt != lenReg - 1'b1) dCnt <= dCnt + 1'b1;
          else begin
            dCnt  <= '0;
            state <= (opReg == OP_RNDIN) ? S_FIN : S_CMD2;
          end
        end
        S_CMD2: if (stepDone) begin
          if (opReg == OP_RNDOUT) state <= (lenReg == '0) ? S_FIN : S_RDATA;
          else                    state <= S_WLOW;
        end
        S_WLOW:  if (!rbOk) state <= S_WHIGH;
        S_WHIGH: if (rbOk) begin
          if (opReg == OP_READ || opReg == OP_CREAD) state <= (lenReg == '0) ? S_FIN : S_RDATA;
          else if (opReg == OP_RESET)                state <= S_FIN;
          else                                       state <= S_STCMD;
        end
        S_STCMD: if (stepDone) state <= S_STRD;
        S_STRD:  if (stepDone) state <= S_FIN;
        S_RDATA: if (stepDone) begin
          if (dCnt != lenReg - 1'b1) dCnt <= dCnt + 1'b1;
          else state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3 R5 R8: a failure is only reported by status-polled or refused operations
  assert_fail_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (opReg == OP_PROG || opReg == OP_CPROG || opReg == OP_ERASE ||
              opReg == OP_RNDOUT || 4'(opReg) > 4'd9));
  // R2: words are only handed out while an operation is in progress
  assert_rd_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !reqReady);
  // R11: reset completes only with the ready line high
  assert_reset_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && opReg == OP_RESET) |-> rbN);
endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int COLW   = 12,
  parameter int ROWW   = 16,
  parameter int LENW   = 8,
  parameter int WE_LO  = 2,
  parameter int WE_HI  = 2,
  parameter int RE_LO  = 3,
  parameter int RE_HI  = 2,
  parameter int RE_SMP = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [3:0]      reqOp,
  input  logic [ROWW-1:0] reqRow,
  input  logic [COLW-1:0] reqCol,
  input  logic [LENW-1:0] reqLen,
  input  logic [15:0]     wrData,
  output logic            wrTake,
  output logic [15:0]     rdData,
  output logic            rdValid,
  output logic            done,
  output logic            fail,
  output logic            cle,
  output logic            ale,
  output logic            ceN,
  output logic            weN,
  output logic            reN,
  output logic            wpN,
  output logic [15:0]     ioOut,
  output logic            ioOe,
  input  logic [15:0]     ioIn,
  input  logic            rbN
);
  strobe_t     stb;
  logic        cycDone, sampleValid;
  logic [15:0] sampleData;

  nand_seq_ctrl #(.COLW(COLW), .ROWW(ROWW), .LENW(LENW), .SYNCN(2)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(op_e'(reqOp)), .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .done(done), .fail(fail), .rbN(rbN), .stb(stb), .cycDone(cycDone),
    .sampleValid(sampleValid), .sampleData(sampleData)
  );

  nand_seq_dpath #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
                   .RE_SMP(RE_SMP)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .ioIn(ioIn), .cycDone(cycDone),
    .sampleValid(sampleValid), .sampleData(sampleData), .cle(cle), .ale(ale),
    .ceN(ceN), .weN(weN), .reN(reN), .wpN(wpN), .ioOut(ioOut), .ioOe(ioOe)
  );

  // R13: program and erase confirm codes are only written with protection lifted
  assert_wp_on_confirm_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && cle && (ioOut[7:0] == 8'h10 || ioOut[7:0] == 8'h15 || ioOut[7:0] == 8'hD0))
      |-> wpN);
endmodule

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;
  localparam int CLK = 10;
  localparam int COLW = 12, ROWW = 16, LENW = 8;
  localparam int WE_LO = 2, RE_LO = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [3:0] reqOp = '0;
  logic [ROWW-1:0] reqRow = '0;
  logic [COLW-1:0] reqCol = '0;
  logic [LENW-1:0] reqLen = '0;
  logic [15:0] wrData, rdData, ioOut, ioIn;
  logic reqReady, wrTake, rdValid, done, fail, cle, ale, ceN, weN, reN, wpN, ioOe;
  logic rbN = 1'b1;

  int checks = 0, errors = 0;
  int wrIdx = 0;
  int logCnt = 0, rdCnt = 0, expCnt = 0;
  int logKind[64], expKind[64];
  logic [15:0] logVal[64], expVal[64], rdLog[64];
  logic logWp[64];
  logic doneSeen = 1'b0, failSeen = 1'b0;
  int doneBusy = 0;
  int weBad = 0, reBad = 0, weCnt = 0, reCnt = 0;
  int busyReq = 0, busySeen = 0, busyCnt = 0, busyLen = 5;
  logic [7:0] lastCmd = 8'h00;
  int readIdx = 0;
  logic [7:0] statusVal = 8'hE0;
  logic prevWe = 1'b1, prevRe = 1'b1;
  time weFallT = 0, reFallT = 0;
  logic [15:0] respWord;

  always #(CLK/2) clk = ~clk;

  nand_cmd_seq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqRow(reqRow), .reqCol(reqCol), .reqLen(reqLen), .wrData(wrData), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid), .done(done), .fail(fail), .cle(cle), .ale(ale),
    .ceN(ceN), .weN(weN), .reN(reN), .wpN(wpN), .ioOut(ioOut), .ioOe(ioOe),
    .ioIn(ioIn), .rbN(rbN)
  );

  function automatic logic [15:0] pageWord(int i);
    return 16'h5A00 ^ 16'(i * 16'h0111);
  endfunction
  function automatic logic [15:0] idWord(int i);
    case (i)
      0: return 16'h00AD;
      1: return 16'h00DA;
      2: return 16'h0080;
      3: return 16'h0015;
      default: return 16'h0000;
    endcase
  endfunction
  function automatic logic [15:0] wrWord(int i);
    return 16'hC300 + 16'(i * 19);
  endfunction

  assign wrData = wrWord(wrIdx);
  always @(posedge clk) if (wrTake) wrIdx <= wrIdx + 1;

  always @* begin
    if (lastCmd == 8'h90)      respWord = idWord(readIdx);
    else if (lastCmd == 8'h70) respWord = {8'h00, statusVal};
    else                       respWord = pageWord(readIdx);
  end
  assign ioIn = !reN ? respWord : 16'h0000;

  // flash model: logs each latched cycle and measures strobe widths
  always @(weN or reN) begin
    if (weN && !prevWe) begin
      weCnt++;
      if ((($time - weFallT) / CLK) != WE_LO) weBad++;
      if (logCnt < 64) begin
        logKind[logCnt] = cle ? 0 : (ale ? 1 : 2);
        logVal[logCnt]  = ioOut;
        logWp[logCnt]   = wpN;
        logCnt++;
      end
      if (cle) begin
        lastCmd = ioOut[7:0];
        readIdx = 0;
        if (ioOut[7:0] == 8'h30 || ioOut[7:0] == 8'h31 || ioOut[7:0] == 8'h10 ||
            ioOut[7:0] == 8'h15 || ioOut[7:0] == 8'hD0 || ioOut[7:0] == 8'hFF)
          busyReq++;
      end
    end
    if (!weN && prevWe) weFallT = $time;
    if (reN && !prevRe) begin
      reCnt++;
      if ((($time - reFallT) / CLK) != RE_LO) reBad++;
      if (logCnt < 64) begin
        logKind[logCnt] = 3;
        logVal[logCnt]  = respWord;
        logWp[logCnt]   = wpN;
        logCnt++;
      end
      readIdx++;
    end
    if (!reN && prevRe) reFallT = $time;
    prevWe = weN;
    prevRe = reN;
  end

  always @(posedge clk) begin
    if (busySeen != busyReq) begin
      busySeen <= busyReq;
      busyCnt  <= busyLen;
      rbN      <= 1'b0;
    end else if (busyCnt > 0) begin
      busyCnt <= busyCnt - 1;
      if (busyCnt == 1) rbN <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (done) begin
      doneSeen = 1'b1;
      failSeen = fail;
      if (!rbN) doneBusy++;
    end
    if (rdValid && rdCnt < 64) begin
      rdLog[rdCnt] = rdData;
      rdCnt++;
    end
  end

  task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expClear(); expCnt = 0; endtask
  task automatic expPush(int k, logic [15:0] v);
    expKind[expCnt] = k; expVal[expCnt] = v; expCnt++;
  endtask
  task automatic expColRow(logic [COLW-1:0] col, logic [ROWW-1:0] row, logic withCol, logic withRow);
    if (withCol) begin
      expPush(1, {8'h00, col[7:0]});
      expPush(1, {12'h000, col[11:8]});
    end
    if (withRow) begin
      expPush(1, {8'h00, row[7:0]});
      expPush(1, {8'h00, row[15:8]});
    end
  endtask

  task automatic runOp(logic [3:0] op, logic [ROWW-1:0] row, logic [COLW-1:0] col, int len);
    while (!reqReady) @(negedge clk);
    logCnt = 0; rdCnt = 0; doneSeen = 1'b0; failSeen = 1'b0;
    reqValid = 1'b1; reqOp = op; reqRow = row; reqCol = col; reqLen = LENW'(len);
    @(negedge clk);
    reqValid = 1'b0; reqRow = ~row; reqCol = ~col;
    while (!doneSeen) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkBus(string req);
    int bad = -1;
    for (int i = 0; i < expCnt; i++)
      if (bad < 0 && (i >= logCnt || logKind[i] != expKind[i] || logVal[i] !== expVal[i])) bad = i;
    if (bad < 0 && logCnt != expCnt) bad = expCnt;
    if (bad < 0) check(req, 1'b1, 0, 0);
    else if (bad < logCnt && bad < expCnt)
      check($sformatf("%s bus cycle %0d kind/value", req, bad), 1'b0,
            {logKind[bad][15:0], logVal[bad]}, {expKind[bad][15:0], expVal[bad]});
    else check($sformatf("%s bus cycle count", req), 1'b0, logCnt, expCnt);
  endtask

  task automatic checkWp(string req, logic expWp);
    int bad = 0;
    for (int i = 0; i < logCnt; i++) if (logWp[i] !== expWp) bad++;
    check(req, bad == 0 && wpN == 1'b0, bad, 0);
  endtask

  initial begin
    #(CLK * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", reqReady && ceN && weN && reN && !cle && !ale && !done && !wpN,
          {reqReady, ceN, weN, reN, cle, ale, done, wpN}, 8'b11110000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", reqReady && ceN && !wpN, {reqReady, ceN, wpN}, 3'b110);

    // R2 R14: page read sweep over word counts, top row bit set on odd lengths
    for (int n = 1; n <= 5; n++) begin
      logic [ROWW-1:0] row;
      logic [COLW-1:0] col;
      int bad;
      row = 16'h1357 + 16'(n * 16'h0101) | ((n % 2) ? 16'h8000 : 16'h0000);
      col = 12'h0A5 + 12'(n * 3);
      runOp(4'd0, row, col, n);
      expClear(); expPush(0, 16'h0000); expColRow(col, row, 1, 1); expPush(0, 16'h0030);
      for (int i = 0; i < n; i++) expPush(3, pageWord(i));
      checkBus($sformatf("R2 R14 page read len %0d", n));
      bad = 0;
      for (int i = 0; i < n; i++) if (rdLog[i] !== pageWord(i)) bad++;
      check($sformatf("R2 read data len %0d", n), bad == 0 && rdCnt == n, rdCnt, n);
      check("R2 done pass", doneSeen && !failSeen, failSeen, 0);
      checkWp("R13 read keeps wp low", 1'b0);
    end

    // R8: cache read opens, status keeps it, random output refused
    runOp(4'd1, 16'h4321, 12'h010, 2);
    expClear(); expPush(0, 16'h0000); expColRow(12'h010, 16'h4321, 1, 1); expPush(0, 16'h0031);
    for (int i = 0; i < 2; i++) expPush(3, pageWord(i));
    checkBus("R8 cache read sequence");
    statusVal = 8'hC0;
    runOp(4'd7, '0, '0, 0);
    expClear(); expPush(0, 16'h0070); expPush(3, 16'h00C0);
    checkBus("R9 status sequence");
    check("R9 status word", rdCnt == 1 && rdLog[0] == 16'h00C0, rdLog[0], 16'h00C0);
    runOp(4'd5, '0, 12'h123, 2);
    check("R8 refused random output has no strobes", logCnt == 0, logCnt, 0);
    check("R8 refused random output fails", doneSeen && failSeen, failSeen, 1);

    // R6: after a plain read, random output is allowed
    runOp(4'd0, 16'h0002, 12'h000, 1);
    runOp(4'd5, '0, 12'h123, 2);
    expClear(); expPush(0, 16'h0005); expColRow(12'h123, '0, 1, 0); expPush(0, 16'h00E0);
    for (int i = 0; i < 2; i++) expPush(3, pageWord(i));
    checkBus("R6 random output sequence");
    check("R6 random output data", rdCnt == 2 && rdLog[1] == pageWord(1), rdLog[1], pageWord(1));
    check("R6 random output passes", !failSeen, failSeen, 0);

    // R3: program sweep with passing status, then a failing status
    statusVal = 8'hE0;
    for (int n = 1; n <= 4; n++) begin
      int base;
      logic [ROWW-1:0] row;
      row = 16'h8000 | 16'(n * 16'h0213);
      base = wrIdx;
      runOp(4'd2, row, 12'h040, n);
      expClear(); expPush(0, 16'h0080); expColRow(12'h040, row, 1, 1);
      for (int i = 0; i < n; i++) expPush(2, wrWord(base + i));
      expPush(0, 16'h0010); expPush(0, 16'h0070); expPush(3, 16'h00E0);
      checkBus($sformatf("R3 R14 program len %0d", n));
      check("R3 program pass", doneSeen && !failSeen, failSeen, 0);
      checkWp("R13 program lifts wp", 1'b1);
    end
    statusVal = 8'hE1;
    runOp(4'd2, 16'h0100, 12'h000, 1);
    check("R3 program failure reported", failSeen, failSeen, 1);
    check("R3 no word handed out for status poll", rdCnt == 0, rdCnt, 0);

    // R4: cache program
    statusVal = 8'hE0;
    begin
      int base;
      base = wrIdx;
      runOp(4'd3, 16'h0777, 12'h008, 2);
      expClear(); expPush(0, 16'h0080); expColRow(12'h008, 16'h0777, 1, 1);
      for (int i = 0; i < 2; i++) expPush(2, wrWord(base + i));
      expPush(0, 16'h0015); expPush(0, 16'h0070); expPush(3, 16'h00E0);
      checkBus("R4 cache program sequence");
      checkWp("R13 cache program lifts wp", 1'b1);
    end

    // R5: erase pass and fail
    runOp(4'd4, 16'hA5C3, 12'hFFF, 0);
    expClear(); expPush(0, 16'h0060); expColRow('0, 16'hA5C3, 0, 1);
    expPush(0, 16'h00D0); expPush(0, 16'h0070); expPush(3, 16'h00E0);
    checkBus("R5 erase sequence");
    check("R5 erase pass", !failSeen, failSeen, 0);
    checkWp("R13 erase lifts wp", 1'b1);
    statusVal = 8'hE1;
    runOp(4'd4, 16'h0040, 12'h000, 0);
    check("R5 erase failure reported", failSeen, failSeen, 1);
    statusVal = 8'hE0;

    // R7: random data input
    begin
      int base;
      base = wrIdx;
      runOp(4'd6, '0, 12'h3C1, 3);
      expClear(); expPush(0, 16'h0085); expColRow(12'h3C1, '0, 1, 0);
      for (int i = 0; i < 3; i++) expPush(2, wrWord(base + i));
      checkBus("R7 random input sequence");
      checkWp("R13 random input lifts wp", 1'b1);
    end

    // R10: identifier
    runOp(4'd8, 16'hFFFF, 12'hFFF, 0);
    expClear(); expPush(0, 16'h0090); expPush(1, 16'h0000);
    for (int i = 0; i < 4; i++) expPush(3, idWord(i));
    checkBus("R10 identifier sequence");
    check("R10 manufacturer code first", rdCnt == 4 && rdLog[0] == 16'h00AD, rdLog[0], 16'h00AD);
    check("R10 last identifier word", rdLog[3] == 16'h0015, rdLog[3], 16'h0015);

    // R11: reset with a long busy phase
    busyLen = 40;
    doneBusy = 0;
    runOp(4'd9, '0, '0, 0);
    expClear(); expPush(0, 16'h00FF);
    checkBus("R11 reset sequence");
    check("R11 done only after ready", doneBusy == 0 && rbN, doneBusy, 0);
    busyLen = 5;

    // R12: strobe widths over every cycle above
    check("R12 write strobe width", weBad == 0 && weCnt > 0, weBad, 0);
    check("R12 read strobe width", reBad == 0 && reCnt > 0, reBad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule